// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two 16-bit interval timers behind a byte-wide register bus. The first timer has a full 16-bit reload latch and runs either as a one-shot or as a free-running divider. In free-running mode it reloads from the latch at every timeout. The second timer is always a one-shot, and only its low byte is latched ahead of time. Software programs a timer in two byte writes. The low byte is staged first. The write of the high byte copies the assembled value into the counter, starts it and clears the timer's flag.

Both counters step down by one on each cycle in which the synchronous count-enable input `tick` is high. A timeout raises a single-cycle fire pulse, and that pulse sets a sticky flag. Selected bus reads and writes clear the flags. Interrupt masking and combining are done outside the block. Read data is combinational and is valid in the cycle in which `bus_rd` is high. Write and read strobes take effect on the next clock edge. The bus has no back-pressure, because every access completes in one cycle. The stream handshake therefore does not apply, and all pins are plain control and status signals.

Top module: `tmr_dual`

## Requirements
- R1: After reset, both counters, all latch bytes, both flags and both one-shot arm bits are zero. Reads of every offset return 0x00, and no fire pulse occurs while `tick` is low.
- R2: A write to offset 4 or offset 6 changes only the low byte of the first timer's latch. A read of offset 6 returns the low latch byte and a read of offset 7 returns the high latch byte.
- R3: A write to offset 5 stores the data as the high latch byte and loads the counter with {data, low latch}. It also clears the first timer's flag and arms its one-shot.
- R4: A write to offset 7 stores the high latch byte and clears the first timer's flag. It leaves the counter value unchanged.
- R5: Each counter decrements by exactly one per cycle with `tick` high and holds its value otherwise. Offset 4 reads the first counter's low byte and offset 5 reads its high byte.
- R6: A timeout is a cycle with `tick` high while the counter is 0x0000. When a timeout is permitted, the fire output pulses high in that cycle and the matching flag reads 1 from the next cycle on.
- R7: With `t1_freerun` low, the first timer fires only on its first timeout after a write to offset 5. At every timeout its counter wraps to 0xFFFF and keeps counting.
- R8: With `t1_freerun` high, every timeout of the first timer fires and reloads the counter from the 16-bit latch. This holds even without a prior load, so the fire period is latch+1 ticks.
- R9: A read of offset 4 clears the first timer's flag. If a fire occurs in the same cycle as any clearing access, the flag is set.
- R10: A write to offset 8 stores the second timer's low latch. A write to offset 9 loads that counter with {data, low latch}, clears the second timer's flag and arms it. A read of offset 8 returns the low counter byte and clears the flag, and a read of offset 9 returns the high counter byte.
- R11: The second timer fires only on its first timeout after a write to offset 9. At every timeout its counter wraps to 0xFFFF and keeps counting.
- R12: A counter load by write has priority over `tick` in the same cycle. The loaded value is not decremented and no fire occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| t1_freerun | input | 1 | First timer free-running (1) or one-shot (0) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clearing side effects) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when bus_rd is low |
| t1_fire | output | 1 | First timer flag-set pulse |
| t2_fire | output | 1 | Second timer flag-set pulse |
| t1_flag | output | 1 | First timer sticky flag |
| t2_flag | output | 1 | Second timer sticky flag |

## Verification
The hardest situation to reach from the ports is a one-shot counter that has already fired, wrapped through 0xFFFF and come back to zero. A second fire there would be a silent bug, and it takes more than 65,536 enabled cycles to reach. The bench loads both timers with small values and then holds `tick` high for a run longer than a full wrap, counting fire pulses on each timer. Random register traffic with mostly zero high bytes then provokes frequent timeouts, including timeouts that coincide with flag-clearing reads and with loads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_T1_CNT_LO = 4;
  localparam int unsigned OFS_T1_CNT_HI = 5;
  localparam int unsigned OFS_T1_LAT_LO = 6;
  localparam int unsigned OFS_T1_LAT_HI = 7;
  localparam int unsigned OFS_T2_CNT_LO = 8;
  localparam int unsigned OFS_T2_CNT_HI = 9;

  // strobes for the reloadable timer
  typedef struct packed {
    logic lat_lo_wr;
    logic load_wr;
    logic lat_hi_wr;
    logic clr_rd;
  } t1_strb_t;

  // strobes for the one-shot timer
  typedef struct packed {
    logic lat_lo_wr;
    logic load_wr;
    logic clr_rd;
  } t2_strb_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output tmr_pkg::t1_strb_t t1_o,
  output tmr_pkg::t2_strb_t t2_o
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_T1_LO  = ADDR_W'(OFS_T1_CNT_LO);
  localparam logic [ADDR_W-1:0] A_T1_HI  = ADDR_W'(OFS_T1_CNT_HI);
  localparam logic [ADDR_W-1:0] A_T1_LLO = ADDR_W'(OFS_T1_LAT_LO);
  localparam logic [ADDR_W-1:0] A_T1_LHI = ADDR_W'(OFS_T1_LAT_HI);
  localparam logic [ADDR_W-1:0] A_T2_LO  = ADDR_W'(OFS_T2_CNT_LO);
  localparam logic [ADDR_W-1:0] A_T2_HI  = ADDR_W'(OFS_T2_CNT_HI);

  always_comb begin
    t1_o.lat_lo_wr = wr_i && (addr_i == A_T1_LO || addr_i == A_T1_LLO);
    t1_o.load_wr   = wr_i && (addr_i == A_T1_HI);
    t1_o.lat_hi_wr = wr_i && (addr_i == A_T1_LHI);
    t1_o.clr_rd    = rd_i && (addr_i == A_T1_LO);
    t2_o.lat_lo_wr = wr_i && (addr_i == A_T2_LO);
    t2_o.load_wr   = wr_i && (addr_i == A_T2_HI);
    t2_o.clr_rd    = rd_i && (addr_i == A_T2_LO);
  end
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              freerun_i,
  input  tmr_pkg::t1_strb_t strb_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  lat_o,
  output logic              fire_o,
  output logic              flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BYTE_W-1:0] lat_lo_q, lat_hi_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q, flag_q;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire_o  = tick_i && at_zero && !strb_i.load_wr && (freerun_i || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_lo_q <= '0;
      lat_hi_q <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (strb_i.lat_lo_wr) lat_lo_q <= wdata_i;
      if (strb_i.load_wr || strb_i.lat_hi_wr) lat_hi_q <= wdata_i;

      if (strb_i.load_wr) begin
        cnt_q   <= {wdata_i, lat_lo_q};
        armed_q <= 1'b1;
      end else if (tick_i) begin
        if (at_zero) begin
          if (freerun_i) begin
            cnt_q <= {lat_hi_q, lat_lo_q};
          end else begin
            cnt_q   <= '1;
            armed_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end

      if (fire_o) flag_q <= 1'b1;
      else if (strb_i.clr_rd || strb_i.load_wr || strb_i.lat_hi_wr) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign lat_o  = {lat_hi_q, lat_lo_q};
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_oneshot.sv
module tmr_oneshot #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  tmr_pkg::t2_strb_t strb_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              fire_o,
  output logic              flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BYTE_W-1:0] lat_lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q, flag_q;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire_o  = tick_i && at_zero && armed_q && !strb_i.load_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_lo_q <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (strb_i.lat_lo_wr) lat_lo_q <= wdata_i;

      if (strb_i.load_wr) begin
        cnt_q   <= {wdata_i, lat_lo_q};
        armed_q <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= cnt_q - ONE;
        if (at_zero) armed_q <= 1'b0;
      end

      if (fire_o) flag_q <= 1'b1;
      else if (strb_i.clr_rd || strb_i.load_wr) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              t1_freerun,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              t1_fire,
  output logic              t2_fire,
  output logic              t1_flag,
  output logic              t2_flag
);
  import tmr_pkg::*;

  localparam int unsigned CNT_W = 2 * BYTE_W;

  t1_strb_t          t1_strb;
  t2_strb_t          t2_strb;
  logic [CNT_W-1:0]  t1_cnt, t1_lat, t2_cnt;

  tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i   (bus_wr),
    .rd_i   (bus_rd),
    .addr_i (bus_addr),
    .t1_o   (t1_strb),
    .t2_o   (t2_strb)
  );

  tmr_reload #(.BYTE_W(BYTE_W)) u_t1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .freerun_i (t1_freerun),
    .strb_i    (t1_strb),
    .wdata_i   (bus_wdata),
    .cnt_o     (t1_cnt),
    .lat_o     (t1_lat),
    .fire_o    (t1_fire),
    .flag_o    (t1_flag)
  );

  tmr_oneshot #(.BYTE_W(BYTE_W)) u_t2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .strb_i  (t2_strb),
    .wdata_i (bus_wdata),
    .cnt_o   (t2_cnt),
    .fire_o  (t2_fire),
    .flag_o  (t2_flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_T1_CNT_LO))      bus_rdata = t1_cnt[BYTE_W-1:0];
      else if (bus_addr == ADDR_W'(OFS_T1_CNT_HI)) bus_rdata = t1_cnt[CNT_W-1:BYTE_W];
      else if (bus_addr == ADDR_W'(OFS_T1_LAT_LO)) bus_rdata = t1_lat[BYTE_W-1:0];
      else if (bus_addr == ADDR_W'(OFS_T1_LAT_HI)) bus_rdata = t1_lat[CNT_W-1:BYTE_W];
      else if (bus_addr == ADDR_W'(OFS_T2_CNT_LO)) bus_rdata = t2_cnt[BYTE_W-1:0];
      else if (bus_addr == ADDR_W'(OFS_T2_CNT_HI)) bus_rdata = t2_cnt[CNT_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              t1_freerun,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              t1_fire,
  input logic              t2_fire,
  input logic              t1_flag,
  input logic              t2_flag
);
  logic wr5, wr9, rd4;
  logic t1_spent_q, t2_spent_q;

  assign wr5 = bus_wr && (bus_addr == ADDR_W'(5));
  assign wr9 = bus_wr && (bus_addr == ADDR_W'(9));
  assign rd4 = bus_rd && (bus_addr == ADDR_W'(4));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_spent_q <= 1'b0;
      t2_spent_q <= 1'b0;
    end else begin
      if (wr5) t1_spent_q <= 1'b0;
      else if (t1_fire && !t1_freerun) t1_spent_q <= 1'b1;
      if (wr9) t2_spent_q <= 1'b0;
      else if (t2_fire) t2_spent_q <= 1'b1;
    end
  end

  assert_fire_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> (!t1_fire && !t2_fire));
  assert_t1_fire_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t1_fire |=> t1_flag);
  assert_t2_fire_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t2_fire |=> t2_flag);
  assert_t1_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr5 |=> !t1_flag);
  assert_t2_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr9 |=> !t2_flag);
  assert_t1_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd4 && !t1_fire) |=> !t1_flag);
  assert_t1_single_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_fire && !t1_freerun) |-> !t1_spent_q);
  assert_t2_single_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    t2_fire |-> !t2_spent_q);
  assert_load_beats_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr5 |-> !t1_fire) and (wr9 |-> !t2_fire));
endmodule

bind tmr_dual tmr_dual_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .t1_freerun(t1_freerun),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .t1_fire(t1_fire), .t2_fire(t2_fire),
  .t1_flag(t1_flag), .t2_flag(t2_flag)
);

// File: tb/tmr_dual_bench.sv
module tmr_dual_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, t1_freerun = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic t1_fire, t2_fire, t1_flag, t2_flag;

  always #5 clk = ~clk;

  tmr_dual u_tmr_dual (.*);

  int checks = 0, fails = 0;
  int fires1 = 0, fires2 = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m1_cnt, m2_cnt;
  logic [7:0]  m1_lo, m1_hi, m2_lo;
  logic        m1_arm, m2_arm, m1_flag, m2_flag;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic rd, input logic [3:0] a);
    if (!rd) return 8'h00;
    case (a)
      4'd4: return m1_cnt[7:0];
      4'd5: return m1_cnt[15:8];
      4'd6: return m1_lo;
      4'd7: return m1_hi;
      4'd8: return m2_cnt[7:0];
      4'd9: return m2_cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m1_cnt = 0; m2_cnt = 0; m1_lo = 0; m1_hi = 0; m2_lo = 0;
    m1_arm = 0; m2_arm = 0; m1_flag = 0; m2_flag = 0;
  endtask

  // one bus cycle; returns the data read
  task automatic cyc(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d,
                     input logic tk, input logic fr, input string tag, output logic [7:0] rv);
    logic f1, f2, ld1, ld2;
    logic [15:0] n1, n2;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick = tk; t1_freerun = fr;
    #1;
    ld1 = wr && a == 4'd5;
    ld2 = wr && a == 4'd9;
    f1 = tk && m1_cnt == 0 && !ld1 && (fr || m1_arm);
    f2 = tk && m2_cnt == 0 && !ld2 && m2_arm;
    rv = bus_rdata;
    chk(bus_rdata == exp_rd(rd, a), tag, "rdata", bus_rdata, exp_rd(rd, a));
    chk(t1_fire == f1, tag, "t1_fire", t1_fire, f1);
    chk(t2_fire == f2, tag, "t2_fire", t2_fire, f2);
    if (t1_fire) fires1++;
    if (t2_fire) fires2++;
    // next state from the requirements
    n1 = m1_cnt; n2 = m2_cnt;
    if (ld1) begin n1 = {d, m1_lo}; m1_arm = 1; end
    else if (tk) begin
      if (m1_cnt == 0) begin
        if (fr) n1 = {m1_hi, m1_lo}; else begin n1 = 16'hFFFF; m1_arm = 0; end
      end else n1 = m1_cnt - 1;
    end
    if (ld2) begin n2 = {d, m2_lo}; m2_arm = 1; end
    else if (tk) begin n2 = m2_cnt - 1; if (m2_cnt == 0) m2_arm = 0; end
    if (f1) m1_flag = 1;
    else if (ld1 || (wr && a == 4'd7) || (rd && a == 4'd4)) m1_flag = 0;
    if (f2) m2_flag = 1;
    else if (ld2 || (rd && a == 4'd8)) m2_flag = 0;
    if (wr && (a == 4'd4 || a == 4'd6)) m1_lo = d;
    if (ld1 || (wr && a == 4'd7)) m1_hi = d;
    if (wr && a == 4'd8) m2_lo = d;
    m1_cnt = n1; m2_cnt = n2;
    @(posedge clk); #1;
    chk(t1_flag == m1_flag, tag, "t1_flag", t1_flag, m1_flag);
    chk(t2_flag == m2_flag, tag, "t2_flag", t2_flag, m2_flag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tk, input logic fr, input string tag);
    logic [7:0] rv;
    cyc(1, 0, a, d, tk, fr, tag, rv);
  endtask

  task automatic rd(input logic [3:0] a, input logic tk, input logic fr, input string tag, output logic [7:0] rv);
    cyc(0, 1, a, 8'h00, tk, fr, tag, rv);
  endtask

  task automatic idle(input logic tk, input logic fr, input string tag);
    logic [7:0] rv;
    cyc(0, 0, 4'd0, 8'h00, tk, fr, tag, rv);
  endtask

  initial begin
    logic [7:0] v;
    int f1s, f2s;
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(t1_flag == 0 && t2_flag == 0, "R1", "flags after reset", {t1_flag, t2_flag}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), 0, 0, "R1", v);
      chk(v == 8'h00, "R1", "reset readback", v, 0);
    end
    // R2: low latch writes from both offsets, latch readback
    wr(4'd6, 8'h34, 0, 0, "R2");
    wr(4'd4, 8'h03, 0, 0, "R2");
    rd(4'd6, 0, 0, "R2", v);
    chk(v == 8'h03, "R2", "latch lo", v, 8'h03);
    rd(4'd7, 0, 0, "R2", v);
    chk(v == 8'h00, "R2", "latch hi untouched", v, 8'h00);
    rd(4'd4, 0, 0, "R2", v);
    chk(v == 8'h00, "R2", "counter not loaded by lo write", v, 8'h00);
    // R3 + R12: load with tick high in same cycle
    wr(4'd5, 8'h00, 1, 0, "R12");
    rd(4'd4, 0, 0, "R3", v);
    chk(v == 8'h03, "R3", "loaded counter lo", v, 8'h03);
    // R5: two ticks then one idle
    idle(1, 0, "R5"); idle(1, 0, "R5"); idle(0, 0, "R5");
    rd(4'd4, 0, 0, "R5", v);
    chk(v == 8'h01, "R5", "after two ticks", v, 8'h01);
    // R6: reach zero and time out
    idle(1, 0, "R6");
    f1s = fires1;
    idle(1, 0, "R6");
    chk(fires1 == f1s + 1 && t1_flag, "R6", "t1 timeout fired", fires1 - f1s, 1);
    rd(4'd5, 0, 0, "R7", v);
    chk(v == 8'hFF, "R7", "wrap high byte", v, 8'hFF);
    // R4: latch hi write clears flag, counter unchanged
    wr(4'd7, 8'h12, 0, 0, "R4");
    chk(!t1_flag, "R4", "flag cleared", t1_flag, 0);
    rd(4'd5, 0, 0, "R4", v);
    chk(v == 8'hFF, "R4", "counter untouched", v, 8'hFF);
    rd(4'd7, 0, 0, "R2", v);
    chk(v == 8'h12, "R2", "latch hi", v, 8'h12);
    // R10: second timer load and read
    wr(4'd8, 8'h02, 0, 0, "R10");
    wr(4'd9, 8'h00, 0, 0, "R10");
    rd(4'd8, 0, 0, "R10", v);
    chk(v == 8'h02, "R10", "t2 lo", v, 8'h02);
    rd(4'd9, 0, 0, "R10", v);
    chk(v == 8'h00, "R10", "t2 hi", v, 8'h00);
    // R7/R11: long run beyond a full wrap, one fire each
    wr(4'd4, 8'h05, 0, 0, "R7");
    wr(4'd5, 8'h00, 0, 0, "R7");
    f1s = fires1; f2s = fires2;
    for (int i = 0; i < 65560; i++) idle(1, 0, "R7");
    chk(fires1 - f1s == 1, "R7", "one-shot t1 fire count", fires1 - f1s, 1);
    chk(fires2 - f2s == 1, "R11", "one-shot t2 fire count", fires2 - f2s, 1);
    // R10: read of t2 low clears its flag
    rd(4'd8, 0, 0, "R10", v);
    chk(!t2_flag, "R10", "t2 flag cleared by read", t2_flag, 0);
    // R8: free-run period latch+1
    wr(4'd4, 8'h02, 0, 1, "R8");
    wr(4'd5, 8'h00, 0, 1, "R8");
    f1s = fires1;
    for (int i = 0; i < 9; i++) idle(1, 1, "R8");
    chk(fires1 - f1s == 3, "R8", "free-run fires in 9 ticks", fires1 - f1s, 3);
    // R9: read clears, fire in same cycle wins
    rd(4'd4, 0, 1, "R9", v);
    chk(!t1_flag, "R9", "read clears", t1_flag, 0);
    idle(1, 1, "R9"); idle(1, 1, "R9");
    rd(4'd4, 1, 1, "R9", v);
    chk(t1_flag, "R9", "set wins over read clear", t1_flag, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [3:0] a;
      logic [7:0] d;
      logic tk, fr;
      k  = $urandom % 10;
      a  = 4'(4 + $urandom % 6);
      d  = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4);
      tk = ($urandom % 4) != 0;
      fr = ($urandom % 8) < 3;
      if (k < 3)      wr(a, d, tk, fr, "R6");
      else if (k < 6) rd(a, tk, fr, "R9", v);
      else            idle(tk, fr, "R5");
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule